// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block is the receive half of a descriptor-driven network DMA controller. It walks a ring of four-word descriptors in memory. A descriptor is usable only when its ownership flag hands it to the engine. The engine copies frame words arriving on a stream input into the descriptor's buffer. It closes each descriptor with a status word and, optionally, a timestamp, then returns ownership to software.

A frame larger than one buffer spills into the following descriptors. Every descriptor except the final one is closed as an intermediate segment. When the ring runs dry, the engine stops and raises a buffer-unavailable flag. It resumes on a poll pulse or when a new frame start appears. Whether a frame cut short by an empty ring is discarded or held back for later is chosen by a flush-disable control.

Descriptor layout (byte offsets from the descriptor base):

- Word 0, offset 0: bit 31 is ownership (1 means the engine owns it), bit 30 is the error flag, bits [29:16] hold the frame length in bytes, bit 9 is first-segment, bit 8 is last-segment, and bits [7:0] hold the frame status.
- Word 1, offset 4: bits [12:0] hold the buffer size in bytes, and bit 15 is end-of-ring.
- Word 2, offset 8: the buffer address.
- Word 3, offset 12: free for the upper half of the timestamp.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset, and while start is low, the engine issues no memory request, does not assert frame-ready, and holds the buffer-unavailable flag low.
- R2: The engine uses a descriptor only when bit 31 of its word 0 is 1. If a fetched descriptor has bit 31 clear, the engine sets the buffer-unavailable flag, suspends and accepts no frame data.
- R3: Frame words are written in order to consecutive word addresses, starting at the address in word 2. A buffer holds the number of bytes given in word 1 bits [12:0].
- R4: When a buffer fills before the end of the frame and the next descriptor is engine-owned, the current word 0 is written with only bit 9 (first-segment) possibly set. The frame then continues in the next buffer.
- R5: At the end of a frame, word 0 is written with bit 31 clear and bit 8 set. Bits [29:16] hold the total byte count, where every non-final word counts 4 bytes and the final word counts the given byte count of 1 to 4. Bits [7:0] hold the frame status, and bit 9 is set only if the frame started in this descriptor.
- R6: With timestamping enabled at the end of a frame, words 2 and 3 of the last descriptor receive the low and high halves of the timestamp. If the timestamp is marked invalid, both words are written as all ones. With timestamping disabled, both words are left unchanged.
- R7: The next descriptor lies 16 bytes after the current one, unless word 1 bit 15 is set, in which case it lies at the ring base.
- R8: When a buffer fills mid-frame, the next descriptor is host-owned and flushing is enabled, word 0 is written with bits 30 and 8 set and the bytes written so far in bits [29:16]. The flag is raised, and the remaining beats of the frame are consumed up to its end without being stored.
- R9: In the same case with flush-disable high, word 0 is written as an intermediate segment with no error, and the flag is raised. The stream stalls, and after resumption the rest of the frame continues into the next descriptor.
- R10: After closing a frame, the engine fetches the next descriptor. If that descriptor is host-owned, it raises the flag and suspends.
- R11: A suspended engine leaves suspend on a poll pulse, or on a frame start at the stream input. It then refetches the descriptor and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Run enable |
| flush_dis_i | input | 1 | Hold partial frames instead of dropping them |
| poll_i | input | 1 | One-cycle poll demand |
| ts_en_i | input | 1 | Timestamp write-back enable |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| fr_valid_i | input | 1 | Frame beat valid |
| fr_ready_o | output | 1 | Frame beat accepted |
| fr_sof_i | input | 1 | First beat of a frame |
| fr_eof_i | input | 1 | Last beat of a frame |
| fr_data_i | input | 32 | Beat data |
| fr_bytes_i | input | 3 | Valid bytes in the last beat (1 to 4) |
| fr_status_i | input | 8 | Frame status, taken with the last beat |
| fr_ts_i | input | 64 | Frame timestamp, taken with the last beat |
| fr_ts_ok_i | input | 1 | Timestamp valid |
| rbu_o | output | 1 | Buffer-unavailable flag |

## Verification
The bench builds the block with a 16-bit address and a ring base of 0x100, and sets up a four-descriptor ring of 16-byte buffers. Because the buffers are small, a frame of five words or more already crosses a descriptor boundary. A 16-word frame fills the whole ring and wraps back to a descriptor that has already been closed, which exercises the end-of-ring step and the unavailable check after a close. Partly owned rings reach both mid-frame outcomes, flushed and held, as well as both ways out of suspend.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 14;
    localparam int SIZE_W     = 13;
    localparam int DESC_BYTES = 16;
    localparam int OWN_B      = 31;
    localparam int ERR_B      = 30;
    localparam int LEN_LO     = 16;
    localparam int LEN_HI     = LEN_LO + LEN_W - 1;
    localparam int FS_B       = 9;
    localparam int LS_B       = 8;
    localparam int EOR_B      = 15;

    typedef enum logic [3:0] {
        S_IDLE, S_F0, S_F1, S_F2, S_F3, S_WAIT, S_DATA,
        S_NX0, S_NX1, S_TS2, S_TS3, S_W0, S_FLUSH, S_SUSP
    } rxd_state_e;

    typedef enum logic [1:0] { CK_EOF, CK_MID, CK_ERR } close_e;
endpackage

// File: rtl/rxd_ring_step.sv
module rxd_ring_step
    import rxd_pkg::*;
#(
    parameter int          AW   = 16,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic [AW-1:0] cur_i,
    input  logic          eor_i,
    output logic [AW-1:0] nxt_o
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    assign nxt_o = eor_i ? BASE : cur_i + STEP;
endmodule

// File: rtl/rxd_w0_pack.sv
module rxd_w0_pack
    import rxd_pkg::*;
(
    input  close_e             kind_i,
    input  logic               first_i,
    input  logic               flush_dis_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [7:0]         stat_i,
    output logic [WORD_W-1:0]  w0_o
);
    always_comb begin
        w0_o       = '0;
        w0_o[FS_B] = first_i;
        case (kind_i)
            CK_EOF: begin
                w0_o[LS_B]          = 1'b1;
                w0_o[LEN_HI:LEN_LO] = len_i;
                w0_o[7:0]           = stat_i;
            end
            CK_ERR: begin
                if (!flush_dis_i) begin
                    w0_o[ERR_B]         = 1'b1;
                    w0_o[LS_B]          = 1'b1;
                    w0_o[LEN_HI:LEN_LO] = len_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
    import rxd_pkg::*;
#(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] RING_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flush_dis_i,
    input  logic              poll_i,
    input  logic              ts_en_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              fr_valid_i,
    output logic              fr_ready_o,
    input  logic              fr_sof_i,
    input  logic              fr_eof_i,
    input  logic [WORD_W-1:0] fr_data_i,
    input  logic [2:0]        fr_bytes_i,
    input  logic [7:0]        fr_status_i,
    input  logic [2*WORD_W-1:0] fr_ts_i,
    input  logic              fr_ts_ok_i,
    output logic              rbu_o
);
    localparam logic [AW-1:0]     WSTEP = AW'(WORD_W / 8);
    localparam logic [SIZE_W-1:0] WBYTES = SIZE_W'(WORD_W / 8);

    typedef struct packed {
        rxd_state_e          st;
        logic [AW-1:0]       cur;
        logic [AW-1:0]       bptr;
        logic [SIZE_W-1:0]   left;
        logic                eor;
        logic                in_frame;
        logic                fs;
        logic [LEN_W-1:0]    flen;
        logic [7:0]          stat;
        logic [2*WORD_W-1:0] ts;
        logic                ts_ok;
        close_e              ck;
        logic                rbu;
    } regs_t;

    regs_t r_d, r_q;
    logic [AW-1:0]     step_addr;
    logic [WORD_W-1:0] close_w0;
    logic              unused_rdata;

    assign unused_rdata = ^mem_rdata_i[30:16];

    rxd_ring_step #(.AW(AW), .BASE(RING_BASE)) u_step (
        .cur_i (r_q.cur),
        .eor_i (r_q.eor),
        .nxt_o (step_addr)
    );

    rxd_w0_pack u_pack (
        .kind_i      (r_q.ck),
        .first_i     (r_q.fs),
        .flush_dis_i (flush_dis_i),
        .len_i       (r_q.flen),
        .stat_i      (r_q.stat),
        .w0_o        (close_w0)
    );

    always_comb begin
        r_d         = r_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        fr_ready_o  = 1'b0;
        case (r_q.st)
            S_IDLE: if (start_i) r_d.st = S_F0;
            S_F0: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur;
                r_d.st     = S_F1;
            end
            S_F1: begin
                if (mem_rdata_i[OWN_B]) begin
                    mem_req_o  = 1'b1;
                    mem_addr_o = r_q.cur + WSTEP;
                    r_d.st     = S_F2;
                end else begin
                    r_d.rbu = 1'b1;
                    r_d.st  = S_SUSP;
                end
            end
            S_F2: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + 2 * WSTEP;
                r_d.left   = mem_rdata_i[SIZE_W-1:0];
                r_d.eor    = mem_rdata_i[EOR_B];
                r_d.st     = S_F3;
            end
            S_F3: begin
                r_d.bptr = mem_rdata_i[AW-1:0];
                r_d.st   = r_q.in_frame ? S_DATA : S_WAIT;
            end
            S_WAIT: begin
                if (!start_i) begin
                    r_d.st = S_IDLE;
                end else if (fr_valid_i && fr_sof_i) begin
                    r_d.in_frame = 1'b1;
                    r_d.fs       = 1'b1;
                    r_d.flen     = '0;
                    r_d.st       = S_DATA;
                end
            end
            S_DATA: begin
                fr_ready_o = 1'b1;
                if (fr_valid_i) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = r_q.bptr;
                    mem_wdata_o = fr_data_i;
                    r_d.bptr    = r_q.bptr + WSTEP;
                    r_d.left    = (r_q.left > WBYTES) ? r_q.left - WBYTES : '0;
                    r_d.flen    = r_q.flen + (fr_eof_i ? LEN_W'(fr_bytes_i) : LEN_W'(WORD_W / 8));
                    if (fr_eof_i) begin
                        r_d.stat     = fr_status_i;
                        r_d.ts       = fr_ts_i;
                        r_d.ts_ok    = fr_ts_ok_i;
                        r_d.ck       = CK_EOF;
                        r_d.in_frame = 1'b0;
                        r_d.st       = ts_en_i ? S_TS2 : S_W0;
                    end else if (r_q.left <= WBYTES) begin
                        r_d.st = S_NX0;
                    end
                end
            end
            S_NX0: begin
                mem_req_o  = 1'b1;
                mem_addr_o = step_addr;
                r_d.st     = S_NX1;
            end
            S_NX1: begin
                r_d.ck = mem_rdata_i[OWN_B] ? CK_MID : CK_ERR;
                r_d.st = S_W0;
            end
            S_TS2: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.cur + 2 * WSTEP;
                mem_wdata_o = r_q.ts_ok ? r_q.ts[WORD_W-1:0] : '1;
                r_d.st      = S_TS3;
            end
            S_TS3: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.cur + 3 * WSTEP;
                mem_wdata_o = r_q.ts_ok ? r_q.ts[2*WORD_W-1:WORD_W] : '1;
                r_d.st      = S_W0;
            end
            S_W0: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.cur;
                mem_wdata_o = close_w0;
                r_d.cur     = step_addr;
                r_d.fs      = 1'b0;
                if (r_q.ck == CK_ERR) begin
                    r_d.rbu = 1'b1;
                    if (flush_dis_i) begin
                        r_d.st = S_SUSP;
                    end else begin
                        r_d.in_frame = 1'b0;
                        r_d.st       = S_FLUSH;
                    end
                end else begin
                    r_d.st = S_F0;
                end
            end
            S_FLUSH: begin
                fr_ready_o = 1'b1;
                if (fr_valid_i && fr_eof_i) r_d.st = S_SUSP;
            end
            S_SUSP: begin
                if (!start_i) begin
                    r_d.rbu = 1'b0;
                    r_d.st  = S_IDLE;
                end else if (poll_i || (fr_valid_i && fr_sof_i)) begin
                    r_d.rbu = 1'b0;
                    r_d.st  = S_F0;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= S_IDLE;
            r_q.cur <= RING_BASE;
            r_q.ck  <= CK_EOF;
        end else begin
            r_q <= r_d;
        end
    end

    assign rbu_o = r_q.rbu;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> (!mem_req_o && !fr_ready_o));

    // R11
    rbu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rbu_o) |-> ($past(r_q.st) == S_SUSP));

    // R2
    rbu_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbu_o |-> (r_q.st == S_SUSP || r_q.st == S_FLUSH));

    // R3
    buf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DATA) |-> (r_q.left != '0));

    // R8
    flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FLUSH && fr_valid_i && fr_eof_i) |=> (r_q.st == S_SUSP));
endmodule

// File: tb/rx_desc_engine_test.sv
`timescale 1ns/1ps
module rx_desc_engine_test;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;
    localparam logic [AW-1:0] BUFB = 16'h0200;
    localparam int NV = 6;
    // {words[7:0], last bytes[3:0], status[7:0], 2'b0, ts_en, ts_ok}
    localparam logic [23:0] VECS [0:NV-1] = '{
        {8'd3,  4'd2, 8'h5A, 4'b0000},
        {8'd4,  4'd4, 8'h11, 4'b0011},
        {8'd5,  4'd1, 8'h22, 4'b0010},
        {8'd9,  4'd3, 8'h33, 4'b0000},
        {8'd16, 4'd4, 8'h44, 4'b0011},
        {8'd1,  4'd4, 8'h66, 4'b0011}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, flush_dis_i = 0, poll_i = 0, ts_en_i = 0;
    logic mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o, rdata;
    logic fr_valid_i = 0, fr_ready_o, fr_sof_i = 0, fr_eof_i = 0;
    logic [31:0] fr_data_i = '0;
    logic [2:0]  fr_bytes_i = 3'd4;
    logic [7:0]  fr_status_i = '0;
    logic [63:0] fr_ts_i = '0;
    logic fr_ts_ok_i = 0, rbu_o;
    logic [31:0] mem [0:1023];
    int total = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_desc_engine #(.AW(AW), .RING_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_dis_i(flush_dis_i),
        .poll_i(poll_i), .ts_en_i(ts_en_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata),
        .fr_valid_i(fr_valid_i), .fr_ready_o(fr_ready_o), .fr_sof_i(fr_sof_i),
        .fr_eof_i(fr_eof_i), .fr_data_i(fr_data_i), .fr_bytes_i(fr_bytes_i),
        .fr_status_i(fr_status_i), .fr_ts_i(fr_ts_i), .fr_ts_ok_i(fr_ts_ok_i),
        .rbu_o(rbu_o)
    );

    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
            else          rdata <= mem[mem_addr_o[11:2]];
        end
    end

    function automatic int didx(int k); return (BASE >> 2) + 4 * k; endfunction
    function automatic int bidx(int k); return (BUFB >> 2) + 16 * k; endfunction
    function automatic logic [31:0] pat(int tag, int w);
        return 32'h0DA7_0000 | (tag << 8) | w;
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        start_i = 0; flush_dis_i = 0; poll_i = 0; ts_en_i = 0;
        fr_valid_i = 0; fr_sof_i = 0; fr_eof_i = 0;
        rst_n = 0;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
    endtask

    task automatic setup_ring(logic [3:0] own);
        for (int k = 0; k < 4; k++) begin
            mem[didx(k)]     = own[k] ? 32'h8000_0000 : 32'h0;
            mem[didx(k) + 1] = ((k == 3) ? 32'h0000_8000 : 32'h0) | 32'd16;
            mem[didx(k) + 2] = 32'(BUFB) + 32'(64 * k);
            mem[didx(k) + 3] = 32'h3333_0000 + 32'(k);
            for (int j = 0; j < 16; j++) mem[bidx(k) + j] = '0;
        end
    endtask

    task automatic beat(logic [31:0] d, logic sof, logic eof, logic [2:0] nb, output logic ok);
        int cnt = 0;
        fr_valid_i = 1; fr_data_i = d; fr_sof_i = sof; fr_eof_i = eof; fr_bytes_i = nb;
        while (!fr_ready_o && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        ok = fr_ready_o;
        @(negedge clk);
        fr_valid_i = 0; fr_sof_i = 0; fr_eof_i = 0;
    endtask

    task automatic send_frame(int tag, int n, int b, logic [7:0] st, logic [63:0] ts,
                              logic tsok, output logic allok);
        logic ok;
        allok = 1;
        fr_status_i = st; fr_ts_i = ts; fr_ts_ok_i = tsok;
        for (int w = 0; w < n; w++) begin
            beat(pat(tag, w), w == 0, w == n - 1, (w == n - 1) ? 3'(b) : 3'd4, ok);
            allok &= ok;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic allok, ok, stalled, anyreq;
        do_reset();
        // R1: quiet while start is low
        anyreq = 0;
        for (int i = 0; i < 6; i++) begin
            anyreq |= mem_req_o | fr_ready_o;
            @(negedge clk);
        end
        chk("R1 no request or ready while stopped", 32'(anyreq), 0);
        chk("R1 flag low after reset", 32'(rbu_o), 0);

        for (int v = 0; v < NV; v++) begin
            int n = int'(VECS[v][23:16]);
            int b = int'(VECS[v][15:12]);
            logic [7:0] st = VECS[v][11:4];
            logic en = VECS[v][1];
            logic tok = VECS[v][0];
            logic [63:0] ts = {32'hC0DE_0000 | 32'(v), 32'h7155_0000 | 32'(v)};
            int len = 4 * (n - 1) + b;
            int nd = (n + 3) / 4;
            do_reset();
            setup_ring(4'hF);
            ts_en_i = en;
            start_i = 1;
            send_frame(v, n, b, st, ts, tok, allok);
            wait_cyc(40);
            chk("R3 all beats accepted", 32'(allok), 1);
            for (int k = 0; k < nd; k++) begin
                logic [31:0] fsb = (k == 0) ? 32'h200 : 32'h0;
                if (k == nd - 1) begin
                    chk("R5 last segment word0", mem[didx(k)],
                        (32'(len) << 16) | fsb | 32'h100 | 32'(st));
                    chk("R6 timestamp low word", mem[didx(k) + 2],
                        !en ? 32'(BUFB) + 32'(64 * k) : (tok ? ts[31:0] : 32'hFFFF_FFFF));
                    chk("R6 timestamp high word", mem[didx(k) + 3],
                        !en ? 32'h3333_0000 + 32'(k) : (tok ? ts[63:32] : 32'hFFFF_FFFF));
                end else begin
                    chk("R4 intermediate word0", mem[didx(k)], fsb);
                end
            end
            for (int j = 0; j < n; j++)
                chk("R3 buffer data", mem[bidx(j / 4) + (j % 4)], pat(v, j));
            if (nd < 4) begin
                chk("R10 next descriptor left owned", mem[didx(nd)], 32'h8000_0000);
                chk("R10 flag low with owned next", 32'(rbu_o), 0);
            end else begin
                chk("R7 wrap reaches closed head, flag set", 32'(rbu_o), 1);
            end
        end

        // R2 and R11: host-owned ring, then poll
        do_reset();
        setup_ring(4'h0);
        start_i = 1;
        wait_cyc(10);
        chk("R2 flag on host-owned fetch", 32'(rbu_o), 1);
        chk("R2 no frame accepted", 32'(fr_ready_o), 0);
        mem[didx(0)] = 32'h8000_0000;
        poll_i = 1;
        wait_cyc(1);
        poll_i = 0;
        wait_cyc(10);
        chk("R11 poll clears flag", 32'(rbu_o), 0);
        send_frame(20, 2, 4, 8'h3C, '0, 0, allok);
        wait_cyc(40);
        chk("R5 frame after poll", mem[didx(0)], (32'd8 << 16) | 32'h300 | 32'h3C);
        chk("R10 host-owned next after close", 32'(rbu_o), 1);

        // R8: mid-frame host-owned next, flushing enabled
        do_reset();
        setup_ring(4'h1);
        start_i = 1;
        send_frame(7, 6, 4, 8'h5C, '0, 0, allok);
        wait_cyc(20);
        chk("R8 remaining beats consumed", 32'(allok), 1);
        chk("R8 error last word0", mem[didx(0)], 32'h4000_0000 | (32'd16 << 16) | 32'h300);
        chk("R8 flag set", 32'(rbu_o), 1);
        chk("R8 next buffer untouched", mem[bidx(1)], 32'h0);
        chk("R8 next word0 untouched", mem[didx(1)], 32'h0);
        // R11: start of frame releases suspend
        mem[didx(1)] = 32'h8000_0000;
        send_frame(8, 2, 4, 8'h77, '0, 0, allok);
        wait_cyc(40);
        chk("R11 start of frame resumes", mem[didx(1)], (32'd8 << 16) | 32'h300 | 32'h77);
        chk("R11 frame data after resume", mem[bidx(1) + 1], pat(8, 1));

        // R9: flush disabled, frame held then continued
        do_reset();
        setup_ring(4'h1);
        flush_dis_i = 1;
        start_i = 1;
        fr_status_i = 8'h9E;
        for (int w = 0; w < 4; w++) beat(pat(9, w), w == 0, 0, 3'd4, ok);
        fr_valid_i = 1; fr_data_i = pat(9, 4); fr_sof_i = 0; fr_eof_i = 0;
        stalled = 1;
        for (int i = 0; i < 20; i++) begin
            if (fr_ready_o) stalled = 0;
            @(negedge clk);
        end
        chk("R9 stream stalls", 32'(stalled), 1);
        chk("R9 intermediate word0 without error", mem[didx(0)], 32'h200);
        chk("R9 flag set", 32'(rbu_o), 1);
        mem[didx(1)] = 32'h8000_0000;
        poll_i = 1;
        wait_cyc(1);
        poll_i = 0;
        beat(pat(9, 4), 0, 0, 3'd4, ok);
        beat(pat(9, 5), 0, 1, 3'd4, ok);
        wait_cyc(40);
        chk("R9 continuation closes", mem[didx(1)], (32'd24 << 16) | 32'h100 | 32'h9E);
        chk("R9 continuation data", mem[bidx(1)], pat(9, 4));
        chk("R9 continuation data end", mem[bidx(1) + 1], pat(9, 5));

        finish_up();
    end
endmodule